// File: doc/BRIEF.md
# Enable-Latched Single-Bit Static Memory

This block models a one-bit-wide static memory whose cycles are framed by an active-low select input. All inputs are sampled on the system clock. A cycle begins on the first clock where the select is seen low after it was seen high. At that edge the block stores the address, the level of the write strobe and the data bit in internal registers. For the rest of the cycle those inputs have no effect.

The write-strobe level stored at the start fixes the kind of cycle until the select returns high. If the strobe was low, the cycle is an early write. The stored data bit is committed to the stored address, and the output-enable flag stays low for the whole cycle. If the strobe was high, the cycle is a read. One clock after the start, the output-enable flag rises and the output presents the bit held at the stored address.

When the select is seen high, the cycle ends. The output is released and every stored value is cleared, so the next falling select can start a fresh cycle. The tri-state pin is represented by a data value and a separate drive-enable flag.

Top module: `latched_bit_sram`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), dq_oe is 0 and dq_out is 0, and no cycle is in progress.
- R2: A cycle starts at a clock edge where sel_n is sampled 0 and sel_n was sampled 1 at the previous edge. At that edge the block stores addr, the level of wr_n and din.
- R3: In a read cycle (wr_n stored as 1), dq_oe becomes 1 at the edge after the start edge if sel_n is still 0. While sel_n stays 0, dq_out equals the bit stored at the captured address. dq_oe returns to 0 at the first edge where sel_n is sampled 1.
- R4: In an early-write cycle (wr_n stored as 0), dq_oe stays 0 for every clock of the cycle.
- R5: In an early-write cycle, the stored data bit is written to the stored address at the edge after the start edge, even if sel_n is already 1 at that edge. A later read cycle at that address returns the bit.
- R6: Changes on addr and din after the start edge, while sel_n stays 0, do not change the address read or the address and bit written.
- R7: Changes on wr_n after the start edge do not change the kind of cycle. A read cycle performs no write, and an early-write cycle never drives.
- R8: While sel_n is 1, no cycle runs. dq_oe is 0 from the next edge on, and activity on addr, wr_n and din writes nothing.
- R9: Holding sel_n at 0 across many clocks starts only one cycle. A new cycle needs sel_n to be sampled 1 at one or more edges in between.
- R10: dq_out is 0 whenever dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low cycle select; its falling level starts a cycle |
| wr_n | input | 1 | Write strobe, active low, sampled at cycle start |
| addr | input | ADDR_W | Word address, sampled at cycle start |
| din | input | 1 | Write data bit, sampled at cycle start |
| dq_out | output | 1 | Read data bit (0 when not driving) |
| dq_oe | output | 1 | Output drive enable; 0 represents high impedance |

## Verification
The bench builds the block with ADDR_W = 6, which gives 64 words. At that size every address can be written with an early-write cycle and read back, including the top address, within a short run. A behavioural reference model is compared on every clock. The default 12-bit size runs the same logic with a wider address bus.

// File: rtl/lbs_pkg.sv
// Package: shared types for the enable-latched bit memory.
// Assumes: nothing; holds only type definitions.
package lbs_pkg;
    // Kind of cycle, fixed at the start edge by the write-strobe level.
    typedef enum logic {
        CYC_READ  = 1'b0,
        CYC_WRITE = 1'b1
    } cyc_kind_e;
endpackage

// File: rtl/lbs_cycle_ctrl.sv
// Module: cycle framing, capture registers, output-state latch and write commit.
// Detects the select falling level, stores address, strobe level and data,
// freezes the cycle kind, issues one commit pulse for early writes and
// drives the output-enable state for read cycles.
// Assumes: sel_n, wr_n, addr, din are synchronous to clk.
module lbs_cycle_ctrl
    import lbs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_bit,
    output logic              commit,
    output logic              drive
);
    logic      sel_prev;
    logic      busy;
    cyc_kind_e kind;
    logic      wrote;
    logic      start;

    // Start of cycle: select seen low now, high at the previous edge.
    assign start  = sel_prev & ~sel_n;
    // Single commit pulse for an early-write cycle.
    assign commit = busy & (kind == CYC_WRITE) & ~wrote;

    // Capture, hold and release of the cycle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev <= 1'b1;
            busy     <= 1'b0;
            kind     <= CYC_READ;
            cap_addr <= '0;
            cap_bit  <= 1'b0;
            wrote    <= 1'b0;
        end else begin
            sel_prev <= sel_n;
            if (commit) begin
                wrote <= 1'b1;
            end
            if (busy && sel_n) begin
                busy     <= 1'b0;
                kind     <= CYC_READ;
                cap_addr <= '0;
                cap_bit  <= 1'b0;
                wrote    <= 1'b0;
            end else if (start) begin
                busy     <= 1'b1;
                kind     <= wr_n ? CYC_READ : CYC_WRITE;
                cap_addr <= addr;
                cap_bit  <= din;
                wrote    <= 1'b0;
            end
        end
    end

    // Output-state latch: drive only in a read cycle while still selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive <= 1'b0;
        end else begin
            drive <= busy & (kind == CYC_READ) & ~sel_n;
        end
    end

    AST_WRITE_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind == CYC_WRITE) |-> !drive); // R4
    AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !drive); // R8
    AST_DRIVE_AFTER_READ_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> ($past(busy) && $past(kind) == CYC_READ)); // R3
    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cap_addr) && $stable(cap_bit) && $stable(kind))); // R6
    AST_ONE_START_PER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sel_n) |=> !start); // R9
endmodule

// File: rtl/lbs_bit_array.sv
// Module: single-bit storage array with one synchronous write port and a
// registered read of the same address.
// Assumes: write and read are never requested to conflict in one cycle kind;
// contents are not reset.
module lbs_bit_array #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] a,
    input  logic              wbit,
    output logic              rbit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] cells;

    // Write commit into the array.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[a] <= wbit;
        end
    end

    // Registered read of the addressed bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbit <= 1'b0;
        end else begin
            rbit <= cells[a];
        end
    end
endmodule

// File: rtl/latched_bit_sram.sv
// Module: top of the enable-latched single-bit static memory.
// Ties the cycle controller to the array and gates the read bit with the
// drive flag so that the modelled pin reads 0 when not driven.
// Assumes: synchronous inputs; synchronous active-low reset.
module latched_bit_sram #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dq_out,
    output logic              dq_oe
);
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_bit;
    logic              commit;
    logic              drive;
    logic              rbit;

    lbs_cycle_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .din      (din),
        .cap_addr (cap_addr),
        .cap_bit  (cap_bit),
        .commit   (commit),
        .drive    (drive)
    );

    lbs_bit_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .a     (cap_addr),
        .wbit  (cap_bit),
        .rbit  (rbit)
    );

    // Modelled tri-state pin: value plus drive flag.
    assign dq_oe  = drive;
    assign dq_out = drive & rbit;

    AST_ZERO_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> !dq_out); // R10
endmodule

// File: tb/sim_latched_bit_sram.sv
module sim_latched_bit_sram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          din = 1'b0;
    logic          dq_out;
    logic          dq_oe;

    int    n_vec = 0;
    int    n_bad = 0;
    int    ticks = 0;
    bit    done_flag = 0;
    bit    cmp_on = 0;
    string cur_req = "R3";

    // reference model state
    bit m_prev = 1, m_act = 0, m_wr = 0, m_done = 0, m_d = 0;
    int m_a = 0;
    bit m_oe = 0, m_rd = 0;
    bit m_mem[NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_bit_sram #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit nx_oe, nx_rd;
        if (!rst_n) begin
            m_prev = 1; m_act = 0; m_wr = 0; m_done = 0; m_d = 0; m_a = 0;
            m_oe = 0; m_rd = 0;
        end else begin
            nx_oe = m_act && !m_wr && !sel_n;
            nx_rd = m_mem[m_a];
            if (m_act && m_wr && !m_done) begin
                m_mem[m_a] = m_d;
                m_done = 1;
            end
            if (m_act && sel_n) begin
                m_act = 0; m_wr = 0; m_a = 0; m_d = 0; m_done = 0;
            end else if (m_prev && !sel_n) begin
                m_act = 1; m_wr = !wr_n; m_a = int'(addr); m_d = din; m_done = 0;
            end
            m_prev = sel_n;
            m_oe = nx_oe;
            m_rd = nx_rd;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done_flag) begin
            check(cur_req, "dq_oe", int'(dq_oe), int'(m_oe));
            check(m_oe ? cur_req : "R10", "dq_out", int'(dq_out), m_oe ? int'(m_rd) : 0);
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        ticks++;
        if (ticks > 150000 && !done_flag) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", ticks);
            finish_run();
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sel_n = 1'b1;
        end
    endtask

    // one cycle: start with given strobe; hold low for len clocks; optional disturbance
    task automatic run_cycle(bit w_n, int a, bit d, int len, bit disturb);
        @(negedge clk);
        sel_n = 1'b0; wr_n = w_n; addr = AW'(a); din = d;
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            if (disturb) begin
                addr = AW'(a + 5 + i);
                din  = ~din;
                wr_n = ~wr_n;
            end
        end
        @(negedge clk);
        sel_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic read_and_check(string req, int a, bit exp);
        bit seen;
        seen = 0;
        @(negedge clk);
        sel_n = 1'b0; wr_n = 1'b1; addr = AW'(a);
        @(negedge clk);
        @(negedge clk);
        seen = dq_out;
        check(req, "read-back", int'(seen), int'(exp));
        check(req, "read oe", int'(dq_oe), 1);
        sel_n = 1'b1;
        idle(1);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        check("R1", "oe after reset", int'(dq_oe), 0);
        check("R1", "dout after reset", int'(dq_out), 0);
        rst_n = 1'b1;
        cmp_on = 1;
        idle(2);

        // R5 / R4: early write every address
        cur_req = "R4";
        for (int a = 0; a < NW; a++) begin
            run_cycle(1'b0, a, bit'((a * 7 >> 2) ^ a), 2, 0);
            idle(1);
        end
        // R3 / R2: read every address
        cur_req = "R3";
        for (int a = 0; a < NW; a++) begin
            run_cycle(1'b1, a, 1'b0, 3, 0);
            idle(1);
        end
        read_and_check("R5", NW - 1, bit'(((NW - 1) * 7 >> 2) ^ (NW - 1)));
        read_and_check("R2", 0, 1'b0);

        // R5: select low for only one clock, commit still happens
        cur_req = "R5";
        run_cycle(1'b0, 10, ~m_mem[10], 1, 0);
        idle(1);
        read_and_check("R5", 10, m_mem[10]);

        // R6 / R7: disturbed write, then disturbed read
        cur_req = "R6";
        run_cycle(1'b0, 20, ~m_mem[20], 6, 1);
        idle(1);
        read_and_check("R6", 20, m_mem[20]);
        read_and_check("R6", 26, m_mem[26]);
        cur_req = "R7";
        run_cycle(1'b1, 30, ~m_mem[30], 6, 1);
        idle(1);
        read_and_check("R7", 30, m_mem[30]);

        // R8: activity while deselected writes nothing
        cur_req = "R8";
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sel_n = 1'b1; wr_n = i[0]; addr = AW'(40); din = ~m_mem[40];
            check("R8", "oe deselected", int'(dq_oe), 0);
        end
        read_and_check("R8", 40, m_mem[40]);

        // R9: long low after read, no second start; then back-to-back
        cur_req = "R9";
        run_cycle(1'b1, 3, 1'b0, 20, 1);
        run_cycle(1'b0, 3, ~m_mem[3], 2, 0);
        run_cycle(1'b1, 3, 1'b0, 3, 0);
        idle(2);
        read_and_check("R9", 3, m_mem[3]);

        // R1: reset mid read cycle
        cur_req = "R1";
        @(negedge clk);
        sel_n = 1'b0; wr_n = 1'b1; addr = AW'(5);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "oe after mid-cycle reset", int'(dq_oe), 0);
        sel_n = 1'b1;
        rst_n = 1'b1;
        idle(3);
        finish_run();
    end
endmodule